// File: doc/BRIEF.md
# Power Domain Wake-up Sequencer

This block sequences one switchable power domain that holds several independently gated clock domains. Software posts open and close requests. The block drives the main power switch, the retention supply, the isolation clamps, the save and restore strobes, and one clock enable per clock domain. It pulses a completion signal when each request has been fully handled.

An open request from the off or retention state runs three steps in order:
- Power comes up first.
- A programmable power-settle wait and a programmable restore wait follow.
- Only then are clocks enabled.

The completion pulse comes one cycle after the clocks are enabled. A close request runs in the reverse order: clocks are gated, isolation is applied, state is saved, and the domain then drops to retention or fully off. While the domain is active, each clock enable follows its own request one cycle later.

Requests are held in a one-entry slot. The slot captures a request that arrives during a sequence and serves it once the sequence ends. A later request overwrites an earlier one.

Top module: `pd_wake_seq`

## Requirements
- R1: After reset the domain is off: `pwr_on_o`=0, `ret_on_o`=0, `iso_o`=1, `clk_en_o`=0, `save_o`=0, `restore_o`=0, `done_o`=0.
- R2: An open request sampled at clock edge k, with the domain off or in retention, sets `pwr_on_o` from edge k+1. It then waits `pwr_dly_i`+1 cycles with `restore_o` low, then holds `restore_o` high for `restore_dly_i`+1 cycles.
- R3: Clock enables stay low until the restore wait ends. They then take the value of `clk_req_i` for one cycle with `iso_o` still high. `done_o` pulses in the following cycle, which is edge k+`pwr_dly_i`+`restore_dly_i`+4.
- R4: `iso_o` is high whenever power is off, and during every opening and closing step except the clock-gating step. It is low only once the domain is active.
- R5: While active, `clk_en_o[i]` equals `clk_req_i[i]` as sampled at the previous edge.
- R6: A close request sampled at edge k, with the domain active and no clock requested, runs four steps. It gates all clocks at k+1 with `iso_o` still low. It raises `iso_o` at k+2 and pulses `save_o` at k+3. It drops `pwr_on_o` and pulses `done_o` at k+4.
- R7: `close_ret_i`=1 sampled with the close request ends in retention, with `ret_on_o`=1 from the save step onward. `close_ret_i`=0 ends fully off with `ret_on_o`=0. On wake from retention, `ret_on_o` stays high through the power-settle and restore waits.
- R8: A close request is held without effect while any bit of `clk_req_i` is set. It proceeds at the first edge that sees all of `clk_req_i` low.
- R9: A request that arrives during a sequence is kept and served at the first edge after the sequence ends. If several arrive, the latest one wins; open wins over close in the same cycle.
- R10: An open request while active, or a close-to-retention request while off, changes no output except `done_o`, which pulses at k+1. A close-to-off request while in retention goes to off at k+1 with `done_o` high and `ret_on_o` low.
- R11: A delay value of 0 gives a one-cycle step, so an open with both delays at 0 completes at k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_req_i | input | 1 | Open request, one-cycle pulse |
| close_req_i | input | 1 | Close request, one-cycle pulse |
| close_ret_i | input | 1 | Close target, sampled with the close request: 1 selects retention, 0 selects off |
| clk_req_i | input | NUM_CLK | Per clock domain enable request |
| pwr_dly_i | input | DLY_W | Power-settle wait, in cycles minus one |
| restore_dly_i | input | DLY_W | Restore wait, in cycles minus one |
| pwr_on_o | output | 1 | Main power switch enable |
| ret_on_o | output | 1 | Retention supply enable |
| iso_o | output | 1 | Isolation clamp enable |
| save_o | output | 1 | State save strobe |
| restore_o | output | 1 | State restore strobe, held for the restore wait |
| clk_en_o | output | NUM_CLK | Per clock domain clock enable |
| done_o | output | 1 | Request completion pulse |

## Verification
The assertions check the ordering invariants on every cycle:
- isolation is applied whenever power is off;
- clock enables require power and a finished restore;
- isolation rises only after every clock has been gated;
- power falls only right after a save;
- the retention supply holds across a wake;
- active clock enables track their requests.

The latencies depend on the delay values, so only the bench scenarios can show them. The same holds for the blocked close and its release, the handling of a queued request, the later-request-wins rule, and the no-op acknowledgements.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [3:0] {
    PD_OFF, PD_RET, PD_PUP, PD_RST, PD_CLKON, PD_ACT, PD_GATE, PD_ISO, PD_SAVE
  } pd_state_e;
endpackage

// File: rtl/pd_req_slot.sv
module pd_req_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic close_i,
  input  logic ret_i,
  input  logic take_i,
  output logic vld_o,
  output logic open_o,
  output logic ret_o
);
  logic vld_q, open_q, ret_q;

  // newest request overwrites; open wins a same-cycle tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      open_q <= 1'b0;
      ret_q  <= 1'b0;
    end else if (open_i || close_i) begin
      vld_q  <= 1'b1;
      open_q <= open_i;
      ret_q  <= ret_i;
    end else if (take_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign open_o = open_q;
  assign ret_o  = ret_q;

  assert_take_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> vld_q);
endmodule

// File: rtl/pd_dly_timer.sv
module pd_dly_timer #(
  parameter int DLY_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             sel_i,
  input  logic [DLY_W-1:0] lim_a_i,
  input  logic [DLY_W-1:0] lim_b_i,
  output logic             hit_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] lim;

  assign lim   = sel_i ? lim_b_i : lim_a_i;
  assign hit_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int NUM_CLK = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pend_vld_i,
  input  logic               pend_open_i,
  input  logic               pend_ret_i,
  input  logic [NUM_CLK-1:0] clk_req_i,
  input  logic               tmr_hit_i,
  output logic               take_o,
  output logic               tmr_clr_o,
  output logic               tmr_en_o,
  output logic               tmr_sel_o,
  output logic               pwr_on_o,
  output logic               ret_on_o,
  output logic               iso_o,
  output logic               save_o,
  output logic               restore_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic               done_o
);
  pd_state_e state_q, nxt;
  logic ret_path_q, ret_path_d;
  logic ack_now;
  logic [NUM_CLK-1:0] clk_en_q;
  logic done_q;

  always_comb begin
    nxt        = state_q;
    take_o     = 1'b0;
    ack_now    = 1'b0;
    ret_path_d = ret_path_q;
    unique case (state_q)
      PD_OFF: if (pend_vld_i) begin
        take_o = 1'b1;
        if (pend_open_i) begin nxt = PD_PUP; ret_path_d = 1'b0; end
        else ack_now = 1'b1;
      end
      PD_RET: if (pend_vld_i) begin
        take_o = 1'b1;
        if (pend_open_i) begin nxt = PD_PUP; ret_path_d = 1'b1; end
        else begin
          ack_now = 1'b1;
          if (!pend_ret_i) begin nxt = PD_OFF; ret_path_d = 1'b0; end
        end
      end
      PD_PUP:   if (tmr_hit_i) nxt = PD_RST;
      PD_RST:   if (tmr_hit_i) nxt = PD_CLKON;
      PD_CLKON: nxt = PD_ACT;
      PD_ACT: if (pend_vld_i) begin
        if (pend_open_i) begin take_o = 1'b1; ack_now = 1'b1; end
        else if (clk_req_i == '0) begin
          take_o = 1'b1; nxt = PD_GATE; ret_path_d = pend_ret_i;
        end
      end
      PD_GATE:  nxt = PD_ISO;
      PD_ISO:   nxt = PD_SAVE;
      PD_SAVE:  nxt = ret_path_q ? PD_RET : PD_OFF;
      default:  nxt = PD_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PD_OFF;
      ret_path_q <= 1'b0;
      clk_en_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= nxt;
      ret_path_q <= ret_path_d;
      clk_en_q   <= (nxt == PD_CLKON || nxt == PD_ACT) ? clk_req_i : '0;
      done_q     <= ack_now || state_q == PD_CLKON || state_q == PD_SAVE;
    end
  end

  assign tmr_clr_o = (nxt != state_q);
  assign tmr_en_o  = (state_q == PD_PUP) || (state_q == PD_RST);
  assign tmr_sel_o = (state_q == PD_RST);

  assign pwr_on_o  = !(state_q inside {PD_OFF, PD_RET});
  assign ret_on_o  = (state_q == PD_RET) ||
                     ((state_q inside {PD_PUP, PD_RST, PD_SAVE}) && ret_path_q);
  assign iso_o     = !(state_q inside {PD_ACT, PD_GATE});
  assign save_o    = (state_q == PD_SAVE);
  assign restore_o = (state_q == PD_RST);
  assign clk_en_o  = clk_en_q;
  assign done_o    = done_q;

  assert_iso_unpowered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_o |-> iso_o);
  assert_clk_needs_power_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o != '0) |-> (pwr_on_o && !restore_o));
  assert_clk_after_restore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_en_o != '0) && iso_o) |-> $past(restore_o));
  assert_gate_before_iso_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> ($past(clk_en_o) == '0));
  assert_save_before_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_on_o) |-> $past(save_o));
  assert_ret_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_on_o) && $past(ret_on_o)) |-> ret_on_o);
  assert_clk_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_ACT) |-> (clk_en_o == $past(clk_req_i)));
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq #(
  parameter int NUM_CLK = 2,
  parameter int DLY_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_req_i,
  input  logic               close_req_i,
  input  logic               close_ret_i,
  input  logic [NUM_CLK-1:0] clk_req_i,
  input  logic [DLY_W-1:0]   pwr_dly_i,
  input  logic [DLY_W-1:0]   restore_dly_i,
  output logic               pwr_on_o,
  output logic               ret_on_o,
  output logic               iso_o,
  output logic               save_o,
  output logic               restore_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic               done_o
);
  logic pend_vld, pend_open, pend_ret, take;
  logic tmr_clr, tmr_en, tmr_sel, tmr_hit;

  pd_req_slot u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (open_req_i),
    .close_i(close_req_i),
    .ret_i  (close_ret_i),
    .take_i (take),
    .vld_o  (pend_vld),
    .open_o (pend_open),
    .ret_o  (pend_ret)
  );

  pd_dly_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .sel_i  (tmr_sel),
    .lim_a_i(pwr_dly_i),
    .lim_b_i(restore_dly_i),
    .hit_o  (tmr_hit)
  );

  pd_seq_fsm #(.NUM_CLK(NUM_CLK)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_vld_i (pend_vld),
    .pend_open_i(pend_open),
    .pend_ret_i (pend_ret),
    .clk_req_i  (clk_req_i),
    .tmr_hit_i  (tmr_hit),
    .take_o     (take),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en),
    .tmr_sel_o  (tmr_sel),
    .pwr_on_o   (pwr_on_o),
    .ret_on_o   (ret_on_o),
    .iso_o      (iso_o),
    .save_o     (save_o),
    .restore_o  (restore_o),
    .clk_en_o   (clk_en_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/sim_pd_wake_seq.sv
`timescale 1ns/1ps
module sim_pd_wake_seq;
  localparam int NC = 2;
  localparam int DW = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic open_req_i = 1'b0, close_req_i = 1'b0, close_ret_i = 1'b0;
  logic [NC-1:0] clk_req_i = '0;
  logic [DW-1:0] pwr_dly_i = '0, restore_dly_i = '0;
  logic pwr_on_o, ret_on_o, iso_o, save_o, restore_o, done_o;
  logic [NC-1:0] clk_en_o;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  pd_wake_seq #(.NUM_CLK(NC), .DLY_W(DW)) u0 (.*);

  function automatic int open_lat(int p, int r);
    return p + r + 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic pulse_open();
    open_req_i = 1'b1; tick(); open_req_i = 1'b0;
  endtask

  task automatic pulse_close(input logic ret);
    close_req_i = 1'b1; close_ret_i = ret; tick(); close_req_i = 1'b0;
  endtask

  task automatic do_open(input int p, input int r, input logic from_ret, input logic [NC-1:0] req);
    pwr_dly_i = DW'(p); restore_dly_i = DW'(r); clk_req_i = req;
    pulse_open();
    chk("R2 pwr before accept", pwr_on_o, 0);
    for (int n = 1; n <= open_lat(p, r) + 1; n++) begin
      tick();
      if (n <= p + 1) begin
        chk("R2 pwr_on in settle", pwr_on_o, 1);
        chk("R2 restore low in settle", restore_o, 0);
        chk("R7 ret held in settle", ret_on_o, from_ret);
        chk("R3 clk off in settle", clk_en_o, 0);
        chk("R4 iso in settle", iso_o, 1);
      end else if (n <= p + r + 2) begin
        chk("R2 restore high", restore_o, 1);
        chk("R7 ret held in restore", ret_on_o, from_ret);
        chk("R3 clk off in restore", clk_en_o, 0);
        chk("R3 no done in restore", done_o, 0);
      end else if (n == p + r + 3) begin
        chk("R3 clk on before ack", clk_en_o, req);
        chk("R3 done after clk", done_o, 0);
        chk("R4 iso during clk on", iso_o, 1);
        chk("R2 restore ended", restore_o, 0);
      end else if (n == open_lat(p, r)) begin
        chk("R3 done pulse", done_o, 1);
        chk("R4 iso released", iso_o, 0);
        chk("R3 clk held", clk_en_o, req);
        chk("R7 ret off when active", ret_on_o, 0);
      end else begin
        chk("R3 done single", done_o, 0);
      end
    end
  endtask

  task automatic do_close(input logic ret);
    clk_req_i = '0; tick(); tick();
    pulse_close(ret);
    tick();
    chk("R6 clk gated first", clk_en_o, 0);
    chk("R6 iso low while gating", iso_o, 0);
    chk("R6 pwr on gating", pwr_on_o, 1);
    tick();
    chk("R6 iso raised", iso_o, 1);
    chk("R6 no save yet", save_o, 0);
    tick();
    chk("R6 save pulse", save_o, 1);
    chk("R6 pwr during save", pwr_on_o, 1);
    chk("R7 ret in save", ret_on_o, ret);
    tick();
    chk("R6 pwr off", pwr_on_o, 0);
    chk("R6 done close", done_o, 1);
    chk("R7 ret final", ret_on_o, ret);
    chk("R6 save ended", save_o, 0);
    tick();
    chk("R6 done single", done_o, 0);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 200) begin tick(); cyc++; end
  endtask

  initial begin
    int c;
    logic [NC-1:0] v;
    void'($urandom(32'h5eed_0042));
    repeat (3) tick();
    chk("R1 pwr reset", pwr_on_o, 0);
    chk("R1 ret reset", ret_on_o, 0);
    chk("R1 iso reset", iso_o, 1);
    chk("R1 clk reset", clk_en_o, 0);
    chk("R1 save/restore reset", {save_o, restore_o}, 0);
    chk("R1 done reset", done_o, 0);
    rst_ni = 1'b1; tick();

    do_open(3, 2, 1'b0, 2'b11);

    // R5 clock tracking while active
    for (int i = 0; i < 20; i++) begin
      v = NC'($urandom);
      clk_req_i = v; tick();
      chk("R5 clk follows req", clk_en_o, v);
    end

    // R10 open while active
    pulse_open(); tick();
    chk("R10 open noop done", done_o, 1);
    chk("R10 open noop iso", iso_o, 0);
    chk("R10 open noop pwr", pwr_on_o, 1);
    tick();

    // R8 close blocked by a clock request
    clk_req_i = 2'b01; tick(); tick();
    pulse_close(1'b0);
    repeat (5) tick();
    chk("R8 blocked pwr", pwr_on_o, 1);
    chk("R8 blocked iso", iso_o, 0);
    chk("R8 blocked done", done_o, 0);
    chk("R8 blocked clk", clk_en_o, 2'b01);
    clk_req_i = '0; tick();
    chk("R8 release gates", clk_en_o, 0);
    repeat (3) tick();
    chk("R8 release done", done_o, 1);
    chk("R8 release off", pwr_on_o, 0);
    tick();

    // R10 close-to-retention while off
    pulse_close(1'b1); tick();
    chk("R10 off close done", done_o, 1);
    chk("R10 off close ret", ret_on_o, 0);
    chk("R10 off close pwr", pwr_on_o, 0);
    tick();

    do_open(0, 0, 1'b0, 2'b10);   // R11
    chk("R11 min latency", open_lat(0, 0), 4);
    do_close(1'b1);               // R7
    do_open(5, 4, 1'b1, 2'b01);   // R7 wake from retention
    do_close(1'b1);

    // R10 retention to off
    pulse_close(1'b0); tick();
    chk("R10 ret->off done", done_o, 1);
    chk("R10 ret->off ret", ret_on_o, 0);
    chk("R10 ret->off pwr", pwr_on_o, 0);
    tick();

    // R9 queued close during open
    clk_req_i = '0; pwr_dly_i = 4; restore_dly_i = 4;
    pulse_open(); tick();
    pulse_close(1'b0);
    wait_done(c);
    chk("R9 open completes", pwr_on_o, 1);
    tick(); wait_done(c);
    chk("R9 queued close latency", c, 3);
    chk("R9 queued close off", pwr_on_o, 0);
    tick();

    // R9 later request wins
    pwr_dly_i = 2; restore_dly_i = 2;
    pulse_open(); tick();
    pulse_close(1'b1); tick();
    pulse_open();
    wait_done(c);
    tick();
    chk("R9 later open acked", done_o, 1);
    chk("R9 later open active", iso_o, 0);
    chk("R9 later open pwr", pwr_on_o, 1);
    tick();
    chk("R9 later open done end", done_o, 0);

    // random open/close rounds
    for (int i = 0; i < 12; i++) begin
      logic m;
      m = 1'($urandom);
      do_close(m);
      do_open(int'($urandom_range(0, 12)), int'($urandom_range(0, 12)), m, NC'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule